// File: doc/BRIEF.md
# Double-Buffered Slice Configuration Controller

This block holds the configuration memory for a reconfigurable array divided into independent slices, each made of several tiles. Every slice keeps two planes of configuration words. One plane is active and drives that slice's configuration outputs towards the fabric. The other plane sits in the background, where a new configuration can be written while the fabric keeps running on the active one.

Configuration words arrive on a word-wide port with a valid/ready handshake. Each word carries a slice number, a tile number, a word number within the tile, and a flag that marks it as the last word of the load. A word is always written into the background plane of the named slice. A swap request names one or more slices through a bitmask. At a single clock edge, every named slice flips its plane pointer, so the freshly loaded plane becomes active and the previously active plane becomes the next background. This lets the host stream the next configuration while the current one is in use.

Top module: `slice_cfg_ctrl`

## Requirements
- R1: Reset drives every configuration output bit to 0, clears all background-complete flags and the error flag, and asserts ld_ready.
- R2: An accepted word is stored in the background plane of ld_slice. The cfg_out bus does not change while no swap is accepted. Word w of tile t of slice s appears at cfg_out bits ((s*TILES+t)*WORDS+w)*DW upward, DW bits wide.
- R3: An accepted word with ld_last=1 sets bg_ready[ld_slice]. An accepted word with ld_last=0 clears that bit, because the plane is being rewritten.
- R4: A swap naming only complete slices flips those slices in one clock edge. From the next cycle, their outputs show the loaded plane. The plane they showed before becomes the background that later loads fill.
- R5: All slices named in one swap mask change on the same clock edge.
- R6: A swap whose mask names any slice with bg_ready low is rejected as a whole. No output or flag changes, and swap_err is high for exactly the following cycle.
- R7: An accepted swap clears bg_ready for the slices it named, so a second swap of the same slice without a new load is rejected.
- R8: When a swap names ld_slice in the same cycle as a load, ld_ready is low and the load waits until the swap has taken effect. A load to a slice the swap does not name stays ready.
- R9: A word whose tile or word number is out of range is accepted and its ld_last is honoured, but no stored word changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid | input | 1 | Configuration word present |
| ld_ready | output | 1 | Word can be accepted this cycle |
| ld_slice | input | SW | Target slice |
| ld_tile | input | TW | Target tile within slice |
| ld_word | input | WW | Word within tile |
| ld_data | input | DW | Configuration word |
| ld_last | input | 1 | Final word of the slice load |
| swap_req | input | 1 | Swap command |
| swap_mask | input | SLICES | Slices named by the swap |
| swap_err | output | 1 | Previous cycle's swap was rejected |
| bg_ready | output | SLICES | Background plane complete, per slice |
| cfg_out | output | SLICES*TILES*WORDS*DW | Active configuration of every tile |

## Verification
A load and a swap can fall in the same cycle. The bench provokes this by presenting a word for a slice while a swap names that slice. It checks that ld_ready is low before the edge, that the swap alone takes effect, and that the word then lands in the plane that has just become background, leaving the new active outputs untouched. It also presents a load to a different slice alongside a swap, and checks that both complete at the same edge.

// File: rtl/slice_cfg_ctrl.sv
module slice_cfg_ctrl #(
  parameter int SLICES = 4,
  parameter int TILES  = 3,
  parameter int WORDS  = 4,
  parameter int DW     = 16,
  localparam int SW    = SLICES > 1 ? $clog2(SLICES) : 1,
  localparam int TW    = TILES  > 1 ? $clog2(TILES)  : 1,
  localparam int WW    = WORDS  > 1 ? $clog2(WORDS)  : 1,
  localparam int DEPTH = TILES * WORDS,
  localparam int OUTW  = SLICES * DEPTH * DW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_valid,
  output logic              ld_ready,
  input  logic [SW-1:0]     ld_slice,
  input  logic [TW-1:0]     ld_tile,
  input  logic [WW-1:0]     ld_word,
  input  logic [DW-1:0]     ld_data,
  input  logic              ld_last,
  input  logic              swap_req,
  input  logic [SLICES-1:0] swap_mask,
  output logic              swap_err,
  output logic [SLICES-1:0] bg_ready,
  output logic [OUTW-1:0]   cfg_out
);

  logic [DW-1:0]     mem [SLICES][2][DEPTH];
  logic [SLICES-1:0] act_sel;
  logic [SLICES-1:0] bg_done;
  logic [SLICES-1:0] missing;
  logic              swap_ok, swap_bad, ld_fire, addr_ok;
  int                wr_idx;

  assign ld_ready = !(swap_req && swap_mask[ld_slice]);
  assign ld_fire  = ld_valid && ld_ready;
  assign missing  = swap_mask & ~bg_done;
  assign swap_ok  = swap_req && (missing == '0);
  assign swap_bad = swap_req && (missing != '0);
  assign addr_ok  = (int'(ld_tile) < TILES) && (int'(ld_word) < WORDS);
  assign wr_idx   = int'(ld_tile) * WORDS + int'(ld_word);
  assign bg_ready = bg_done;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_sel  <= '0;
      bg_done  <= '0;
      swap_err <= 1'b0;
      for (int s = 0; s < SLICES; s++)
        for (int p = 0; p < 2; p++)
          for (int i = 0; i < DEPTH; i++)
            mem[s][p][i] <= '0;
    end else begin
      swap_err <= swap_bad;
      for (int s = 0; s < SLICES; s++) begin
        if (swap_ok && swap_mask[s]) begin
          act_sel[s] <= ~act_sel[s];
          bg_done[s] <= 1'b0;
        end else if (ld_fire && int'(ld_slice) == s) begin
          bg_done[s] <= ld_last;
          for (int i = 0; i < DEPTH; i++)
            if (addr_ok && i == wr_idx)
              mem[s][~act_sel[s]][i] <= ld_data;
        end
      end
    end
  end

  for (genvar s = 0; s < SLICES; s++) begin : g_slice
    for (genvar i = 0; i < DEPTH; i++) begin : g_word
      assign cfg_out[(s*DEPTH+i)*DW +: DW] = mem[s][act_sel[s]][i];
    end
  end

endmodule

// File: rtl/slice_cfg_ctrl_chk.sv
module slice_cfg_ctrl_chk #(
  parameter int SLICES = 4,
  parameter int SW     = 2,
  parameter int OUTW   = 768
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ld_valid,
  input logic              ld_ready,
  input logic [SW-1:0]     ld_slice,
  input logic              swap_req,
  input logic [SLICES-1:0] swap_mask,
  input logic              swap_err,
  input logic [SLICES-1:0] act_sel,
  input logic [SLICES-1:0] bg_done,
  input logic [OUTW-1:0]   cfg_out
);

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !swap_req |=> $stable(cfg_out));

  p_flip_r4: assert property (@(posedge clk) disable iff (!rst_n)
    swap_req && ((swap_mask & ~bg_done) == '0) |=> act_sel == ($past(act_sel) ^ $past(swap_mask)));

  p_reject_r6: assert property (@(posedge clk) disable iff (!rst_n)
    swap_req && ((swap_mask & ~bg_done) != '0) |=> swap_err && act_sel == $past(act_sel));

  p_err_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !swap_req |=> !swap_err);

  p_stale_r7: assert property (@(posedge clk) disable iff (!rst_n)
    swap_req && ((swap_mask & ~bg_done) == '0) |=> (bg_done & $past(swap_mask)) == '0);

  p_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid && !ld_ready |-> swap_req && swap_mask[ld_slice]);

endmodule

bind slice_cfg_ctrl slice_cfg_ctrl_chk #(.SLICES(SLICES), .SW(SW), .OUTW(OUTW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_ready(ld_ready),
  .ld_slice(ld_slice), .swap_req(swap_req), .swap_mask(swap_mask),
  .swap_err(swap_err), .act_sel(act_sel), .bg_done(bg_done), .cfg_out(cfg_out)
);

// File: tb/slice_cfg_ctrl_bench.sv
module slice_cfg_ctrl_bench;
  localparam int S = 4, T = 3, W = 4, DW = 16, D = T * W, OW = S * D * DW;

  logic          clk = 0, rst_n = 0;
  logic          ld_valid = 0, ld_last = 0, swap_req = 0;
  logic [1:0]    ld_slice = 0, ld_tile = 0, ld_word = 0;
  logic [DW-1:0] ld_data = 0;
  logic [S-1:0]  swap_mask = 0;
  logic          ld_ready, swap_err;
  logic [S-1:0]  bg_ready;
  logic [OW-1:0] cfg_out;

  int checks = 0, fails = 0;
  logic [DW-1:0] am [S][D];
  logic [DW-1:0] bm [S][D];

  always #4 clk = ~clk;

  slice_cfg_ctrl u_slice_cfg_ctrl (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_ready(ld_ready),
    .ld_slice(ld_slice), .ld_tile(ld_tile), .ld_word(ld_word), .ld_data(ld_data),
    .ld_last(ld_last), .swap_req(swap_req), .swap_mask(swap_mask),
    .swap_err(swap_err), .bg_ready(bg_ready), .cfg_out(cfg_out)
  );

  function automatic logic [OW-1:0] model_out();
    logic [OW-1:0] v;
    for (int s = 0; s < S; s++)
      for (int i = 0; i < D; i++)
        v[(s*D+i)*DW +: DW] = am[s][i];
    return v;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [OW-1:0] act, input logic [OW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_cfg(input string req);
    chk(cfg_out == model_out(), req, cfg_out, model_out());
  endtask

  task automatic model_swap(input logic [S-1:0] m);
    for (int s = 0; s < S; s++)
      if (m[s])
        for (int i = 0; i < D; i++) begin
          logic [DW-1:0] x;
          x = am[s][i]; am[s][i] = bm[s][i]; bm[s][i] = x;
        end
  endtask

  task automatic model_write(input int s, input int t, input int w, input logic [DW-1:0] d);
    if (t < T && w < W) bm[s][t*W+w] = d;
  endtask

  task automatic load(input int s, input int t, input int w, input logic [DW-1:0] d, input bit last);
    @(negedge clk);
    ld_valid = 1; ld_slice = s[1:0]; ld_tile = t[1:0]; ld_word = w[1:0]; ld_data = d; ld_last = last;
    while (!ld_ready) @(negedge clk);
    @(negedge clk);
    ld_valid = 0;
    model_write(s, t, w, d);
  endtask

  task automatic swap(input logic [S-1:0] m, input bit ok, input string req);
    @(negedge clk);
    swap_req = 1; swap_mask = m;
    @(negedge clk);
    swap_req = 0;
    if (ok) model_swap(m);
    chk(swap_err == !ok, req, OW'(swap_err), OW'(!ok));
    chk_cfg(req);
    @(negedge clk);
    chk(swap_err == 0, req, OW'(swap_err), '0);
  endtask

  task automatic t_reset();
    chk(cfg_out == '0, "R1", cfg_out, '0);
    chk(bg_ready == '0, "R1", OW'(bg_ready), '0);
    chk(swap_err == 0 && ld_ready == 1, "R1", OW'({swap_err, ld_ready}), OW'(2'b01));
  endtask

  task automatic t_load_hidden();
    for (int t = 0; t < T; t++)
      for (int w = 0; w < W; w++) begin
        load(0, t, w, DW'(16'h0100 + t*16 + w), (t == T-1) && (w == W-1));
        chk_cfg("R2");
      end
    chk(bg_ready == 4'b0001, "R3", OW'(bg_ready), OW'(4'b0001));
  endtask

  task automatic t_flag_restart();
    load(1, 0, 0, 16'h1111, 1);
    chk(bg_ready[1] == 1, "R3", OW'(bg_ready), OW'(4'b0011));
    load(1, 0, 1, 16'h1112, 0);
    chk(bg_ready == 4'b0001, "R3", OW'(bg_ready), OW'(4'b0001));
  endtask

  task automatic t_swap_pipeline();
    swap(4'b0001, 1, "R4");
    chk(bg_ready == 4'b0000, "R7", OW'(bg_ready), '0);
    load(0, 2, 3, 16'h0A23, 0);
    chk_cfg("R4");
    load(0, 0, 1, 16'h0A01, 1);
    chk_cfg("R2");
    swap(4'b0011, 0, "R6");
    chk(bg_ready == 4'b0001, "R6", OW'(bg_ready), OW'(4'b0001));
    swap(4'b0001, 1, "R4");
    swap(4'b0001, 0, "R7");
  endtask

  task automatic t_multi();
    load(1, 1, 2, 16'h5112, 1);
    load(2, 0, 3, 16'h5203, 1);
    load(3, 2, 0, 16'h5320, 1);
    chk(bg_ready == 4'b1110, "R3", OW'(bg_ready), OW'(4'b1110));
    swap(4'b1110, 1, "R5");
  endtask

  task automatic t_contention();
    load(2, 1, 1, 16'h6211, 1);
    @(negedge clk);
    ld_valid = 1; ld_slice = 2; ld_tile = 2; ld_word = 2; ld_data = 16'h7222; ld_last = 1;
    swap_req = 1; swap_mask = 4'b0100;
    #1 chk(ld_ready == 0, "R8", OW'(ld_ready), '0);
    @(negedge clk);
    swap_req = 0;
    model_swap(4'b0100);
    chk_cfg("R8");
    #1 chk(ld_ready == 1, "R8", OW'(ld_ready), OW'(1));
    @(negedge clk);
    ld_valid = 0;
    model_write(2, 2, 2, 16'h7222);
    chk_cfg("R8");
    chk(bg_ready == 4'b0100, "R8", OW'(bg_ready), OW'(4'b0100));
    @(negedge clk);
    ld_valid = 1; ld_slice = 3; ld_tile = 0; ld_word = 0; ld_data = 16'h7300; ld_last = 0;
    swap_req = 1; swap_mask = 4'b0100;
    #1 chk(ld_ready == 1, "R8", OW'(ld_ready), OW'(1));
    @(negedge clk);
    ld_valid = 0; swap_req = 0;
    model_swap(4'b0100);
    model_write(3, 0, 0, 16'h7300);
    chk_cfg("R8");
  endtask

  task automatic t_range();
    load(3, 3, 0, 16'hDEAD, 1);
    chk(bg_ready == 4'b1000, "R9", OW'(bg_ready), OW'(4'b1000));
    chk_cfg("R9");
    swap(4'b1000, 1, "R9");
  endtask

  initial begin
    for (int s = 0; s < S; s++)
      for (int i = 0; i < D; i++) begin am[s][i] = '0; bm[s][i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_load_hidden();
    t_flag_restart();
    t_swap_pipeline();
    t_multi();
    t_contention();
    t_range();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule